// File: doc/BRIEF.md
# Chained Descriptor DMA Channel

A single-channel DMA engine that moves data between a byte-stream peripheral and a word-addressed memory port. The buffer in flight is described by a current pair of registers: a next address and a limit. A second pair, start and stop, holds the buffer that follows. When the next address meets the limit, the engine either switches straight into the pending pair or halts. An update flag in the status register makes that choice. Chained buffers therefore run with only the single terminal cycle between them.

Software drives the engine through a small register window. Writes to the control/status word are commands. Each address register has a saved copy, and software can read all of them back. The saved copies record where a buffer began and where it actually ended. This covers a short transfer cut off by the peripheral and a transfer aborted by a bus error. The interrupt output follows the complete status bit.

Top module: `dma_chain_chan`

## Requirements
- R1: The register window is addressed by word offset: 0 control/status, 1 next, 2 limit, 3 start, 4 stop, 5 saved next, 6 saved limit, 7 saved start, 8 saved stop. A write to next, limit, start or stop reads back both from that register and from its saved copy. A write of zero to the control/status word changes no status bit.
- R2: The status bits read at offset 0 are: bit 0 enable, bit 1 update, bit 2 read direction, bit 3 complete, bit 4 bus exception. All of them are zero after reset. A command write with bit 5 (reset) and bit 4 (clear-complete) clears enable, update, complete and bus exception.
- R3: Command bit 2 selects read direction and bit 3 selects write direction. In read direction each beat reads memory at the next address and presents the data to the peripheral. In write direction each beat writes peripheral data to memory at the next address.
- R4: Command bit 0 sets enable and bit 1 sets update. When the next address equals the limit while enabled and update is set, the engine sets complete, loads start/stop into next/limit and their saved copies, and clears update. Enable stays set, and the first beat of the new buffer falls two cycles after the last beat of the old one.
- R5: When the next address equals the limit while enabled and update is clear, the engine sets complete, clears enable and issues no further memory requests.
- R6: A pulse on the peripheral end input while enabled and short of the limit halts the engine: complete is set and enable is cleared. The saved limit holds the address reached, so that saved limit minus saved next is the number of beats moved.
- R7: A memory error on a granted beat sets bus exception and complete, clears enable, and leaves the failing address in both next and saved limit.
- R8: The interrupt output equals the complete bit and stays high until a clear-complete or reset command. Writing clear-complete with direction and set-update after loading a new start/stop re-arms chaining from inside the interrupt handler.
- R9: If a clear-complete command lands in the same cycle as a limit event, complete ends up set.
- R10: Command bit 6 (initialise buffer) copies the live next and limit values into saved next and saved limit.
- R11: The next address advances by one per accepted beat, in order. No beat is taken, and the address holds, while the memory grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | AW | Register write data or command bits |
| reg_rdata_o | output | AW | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Completion interrupt |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid with grant |
| mem_gnt_i | input | 1 | Beat accepted this cycle |
| mem_err_i | input | 1 | Accepted beat failed |
| per_in_valid_i | input | 1 | Peripheral has a byte for memory |
| per_in_data_i | input | DW | Peripheral byte for memory |
| per_in_ready_o | output | 1 | Peripheral byte consumed |
| per_out_valid_o | output | 1 | Byte for peripheral valid |
| per_out_data_o | output | DW | Byte for peripheral |
| per_out_ready_i | input | 1 | Peripheral can take a byte |
| per_end_i | input | 1 | Peripheral ends the transfer early |

## Verification
Two functions can fall in the same cycle: the engine's own limit event, which sets complete, and a software clear-complete command, which clears it. The bench times a clear-complete write to be latched on the exact edge where the next address meets the limit. It then judges that the interrupt is still high and the status reads complete. A second race is exercised in the chaining test: the handler writes a new start/stop and set-update while the continue buffer is still streaming. The scoreboard confirms that all three buffers arrive in address order and that there is a two-cycle spacing at the switch.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [3:0] {
    RA_CSR    = 4'd0,
    RA_NEXT   = 4'd1,
    RA_LIMIT  = 4'd2,
    RA_START  = 4'd3,
    RA_STOP   = 4'd4,
    RA_SNEXT  = 4'd5,
    RA_SLIMIT = 4'd6,
    RA_SSTART = 4'd7,
    RA_SSTOP  = 4'd8
  } reg_sel_e;

  localparam int unsigned CMD_EN   = 0;
  localparam int unsigned CMD_UPD  = 1;
  localparam int unsigned CMD_RD   = 2;
  localparam int unsigned CMD_WR   = 3;
  localparam int unsigned CMD_CLR  = 4;
  localparam int unsigned CMD_RST  = 5;
  localparam int unsigned CMD_INIT = 6;
  localparam int unsigned CMD_W    = 7;

  // bit 0 = en ... bit 4 = bex
  typedef struct packed {
    logic bex;
    logic cmp;
    logic rd;
    logic upd;
    logic en;
  } stat_t;
endpackage

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              term_i,
  input  logic              early_i,
  input  logic              berr_i,
  output stat_t             stat_o
);
  stat_t st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= '0;
    end else begin
      if (cmd_we_i) begin
        if (cmd_i[CMD_RST]) begin
          st.en  <= 1'b0;
          st.upd <= 1'b0;
          st.cmp <= 1'b0;
          st.bex <= 1'b0;
        end
        if (cmd_i[CMD_CLR]) st.cmp <= 1'b0;
        if (cmd_i[CMD_RD]) st.rd <= 1'b1;
        else if (cmd_i[CMD_WR]) st.rd <= 1'b0;
        if (cmd_i[CMD_EN]) st.en <= 1'b1;
        if (cmd_i[CMD_UPD]) st.upd <= 1'b1;
      end
      // engine events override commands in the same cycle
      if (berr_i) begin
        st.en  <= 1'b0;
        st.upd <= 1'b0;
        st.cmp <= 1'b1;
        st.bex <= 1'b1;
      end else if (early_i) begin
        st.en  <= 1'b0;
        st.upd <= 1'b0;
        st.cmp <= 1'b1;
      end else if (term_i) begin
        st.cmp <= 1'b1;
        if (st.upd) st.upd <= 1'b0;
        else        st.en  <= 1'b0;
      end
    end
  end

  assign stat_o = st;

  // R2
  rst_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[CMD_RST] && cmd_i[CMD_CLR] && !cmd_i[CMD_EN] && !cmd_i[CMD_UPD]
      && !term_i && !early_i && !berr_i
    |=> !st.en && !st.upd && !st.cmp);

  // R8
  cmp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st.cmp && !(cmd_we_i && (cmd_i[CMD_CLR] || cmd_i[CMD_RST])) |=> st.cmp);

  // R9
  cmp_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && cmd_we_i && cmd_i[CMD_CLR] |=> st.cmp);
endmodule

// File: rtl/dma_chain_addr.sv
module dma_chain_addr
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          beat_i,
  input  logic          switch_i,
  input  logic          capture_i,
  input  logic          init_i,
  output logic [AW-1:0] next_o,
  output logic [AW-1:0] limit_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] stop_o,
  output logic [AW-1:0] snext_o,
  output logic [AW-1:0] slimit_o,
  output logic [AW-1:0] sstart_o,
  output logic [AW-1:0] sstop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_o   <= '0;
      limit_o  <= '0;
      start_o  <= '0;
      stop_o   <= '0;
      snext_o  <= '0;
      slimit_o <= '0;
      sstart_o <= '0;
      sstop_o  <= '0;
    end else begin
      if (wr_i) begin
        unique case (sel_i)
          RA_NEXT:  begin next_o  <= wdata_i; snext_o  <= wdata_i; end
          RA_LIMIT: begin limit_o <= wdata_i; slimit_o <= wdata_i; end
          RA_START: begin start_o <= wdata_i; sstart_o <= wdata_i; end
          RA_STOP:  begin stop_o  <= wdata_i; sstop_o  <= wdata_i; end
          default: ;
        endcase
      end
      if (init_i) begin
        snext_o  <= next_o;
        slimit_o <= limit_o;
      end
      // engine updates win over software writes
      if (beat_i) next_o <= next_o + AW'(1);
      if (switch_i) begin
        next_o   <= start_o;
        limit_o  <= stop_o;
        snext_o  <= sstart_o;
        slimit_o <= sstop_o;
      end
      if (capture_i) slimit_o <= next_o;
    end
  end
endmodule

// File: rtl/dma_chain_port.sv
module dma_chain_port #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 8
) (
  input  logic          en_i,
  input  logic          at_end_i,
  input  logic          halt_i,
  input  logic          dir_rd_i,
  input  logic [AW-1:0] addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_gnt_i,
  input  logic          mem_err_i,
  input  logic          per_in_valid_i,
  input  logic [DW-1:0] per_in_data_i,
  output logic          per_in_ready_o,
  output logic          per_out_valid_o,
  output logic [DW-1:0] per_out_data_o,
  input  logic          per_out_ready_i,
  output logic          beat_o,
  output logic          berr_o
);
  logic go, xfer;

  assign go          = en_i && !at_end_i && !halt_i;
  assign mem_req_o   = go && (dir_rd_i ? per_out_ready_i : per_in_valid_i);
  assign mem_we_o    = !dir_rd_i;
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = per_in_data_i;
  assign xfer        = mem_req_o && mem_gnt_i;
  assign beat_o      = xfer && !mem_err_i;
  assign berr_o      = xfer && mem_err_i;

  assign per_in_ready_o  = beat_o && !dir_rd_i;
  assign per_out_valid_o = beat_o && dir_rd_i;
  assign per_out_data_o  = mem_rdata_i;
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_gnt_i,
  input  logic          mem_err_i,
  input  logic          per_in_valid_i,
  input  logic [DW-1:0] per_in_data_i,
  output logic          per_in_ready_o,
  output logic          per_out_valid_o,
  output logic [DW-1:0] per_out_data_o,
  input  logic          per_out_ready_i,
  input  logic          per_end_i
);
  localparam int unsigned SW = $bits(stat_t);

  stat_t         st;
  reg_sel_e      sel;
  logic [AW-1:0] next_q, limit_q, start_q, stop_q;
  logic [AW-1:0] snext_q, slimit_q, sstart_q, sstop_q;
  logic          csr_we, at_end, term, early, beat, berr, sw_chain;

  assign sel      = reg_sel_e'(reg_addr_i);
  assign csr_we   = reg_we_i && (sel == RA_CSR);
  assign at_end   = (next_q == limit_q);
  assign term     = st.en && at_end;
  assign early    = st.en && !at_end && per_end_i;
  assign sw_chain = term && st.upd;

  dma_chain_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (csr_we),
    .cmd_i    (reg_wdata_i[CMD_W-1:0]),
    .term_i   (term),
    .early_i  (early),
    .berr_i   (berr),
    .stat_o   (st)
  );

  dma_chain_addr #(.AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_we_i),
    .sel_i     (sel),
    .wdata_i   (reg_wdata_i),
    .beat_i    (beat),
    .switch_i  (sw_chain),
    .capture_i (early || berr),
    .init_i    (csr_we && reg_wdata_i[CMD_INIT]),
    .next_o    (next_q),
    .limit_o   (limit_q),
    .start_o   (start_q),
    .stop_o    (stop_q),
    .snext_o   (snext_q),
    .slimit_o  (slimit_q),
    .sstart_o  (sstart_q),
    .sstop_o   (sstop_q)
  );

  dma_chain_port #(.AW(AW), .DW(DW)) u_port (
    .en_i            (st.en),
    .at_end_i        (at_end),
    .halt_i          (per_end_i),
    .dir_rd_i        (st.rd),
    .addr_i          (next_q),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_rdata_i     (mem_rdata_i),
    .mem_gnt_i       (mem_gnt_i),
    .mem_err_i       (mem_err_i),
    .per_in_valid_i  (per_in_valid_i),
    .per_in_data_i   (per_in_data_i),
    .per_in_ready_o  (per_in_ready_o),
    .per_out_valid_o (per_out_valid_o),
    .per_out_data_o  (per_out_data_o),
    .per_out_ready_i (per_out_ready_i),
    .beat_o          (beat),
    .berr_o          (berr)
  );

  assign irq_o = st.cmp;

  always_comb begin
    unique case (sel)
      RA_CSR:    reg_rdata_o = {{(AW-SW){1'b0}}, st};
      RA_NEXT:   reg_rdata_o = next_q;
      RA_LIMIT:  reg_rdata_o = limit_q;
      RA_START:  reg_rdata_o = start_q;
      RA_STOP:   reg_rdata_o = stop_q;
      RA_SNEXT:  reg_rdata_o = snext_q;
      RA_SLIMIT: reg_rdata_o = slimit_q;
      RA_SSTART: reg_rdata_o = sstart_q;
      RA_SSTOP:  reg_rdata_o = sstop_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  // R4
  chain_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_chain && !reg_we_i |=> st.en && !st.upd && st.cmp && next_q == $past(start_q));

  // R5
  limit_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term && !st.upd && !reg_we_i |=> !st.en && st.cmp && !mem_req_o);

  // R6
  early_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early && !reg_we_i |=> !st.en && slimit_q == $past(next_q));

  // R7
  bus_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr && !reg_we_i |=> st.bex && !st.en && slimit_q == $past(next_q) && next_q == $past(next_q));
endmodule

// File: tb/sim_dma_chain_chan.sv
module sim_dma_chain_chan;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int DW = 8;

  localparam logic [3:0] A_CSR = 4'd0, A_NEXT = 4'd1, A_LIMIT = 4'd2, A_START = 4'd3,
                         A_STOP = 4'd4, A_SNEXT = 4'd5, A_SLIMIT = 4'd6,
                         A_SSTART = 4'd7, A_SSTOP = 4'd8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [3:0]    reg_addr_i = '0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic [AW-1:0] reg_rdata_o;
  logic          irq_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic          mem_gnt_i, mem_err_i;
  logic          per_in_valid_i = 1'b0;
  logic [DW-1:0] per_in_data_i;
  logic          per_in_ready_o, per_out_valid_o;
  logic [DW-1:0] per_out_data_o;
  logic          per_out_ready_i = 1'b1;
  logic          per_end_i = 1'b0;

  logic gnt_all = 1'b1, gnt_half = 1'b0, err_en = 1'b0;
  int   cyc = 0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  typedef struct { logic [AW-1:0] a; logic w; } exp_t;
  exp_t q[$];
  logic [AW-1:0] watch_addr = '1;
  int   last_cyc = 0, gap_meas = -1;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_gnt_i     = gnt_all | (gnt_half & cyc[0]);
  assign mem_err_i     = err_en && (mem_addr_o == 32'h303);
  assign mem_rdata_i   = mem_addr_o[7:0] ^ 8'h5A;
  assign per_in_data_i = mem_addr_o[7:0] + 8'h11;

  dma_chain_chan #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_gnt_i(mem_gnt_i),
    .mem_err_i(mem_err_i), .per_in_valid_i(per_in_valid_i), .per_in_data_i(per_in_data_i),
    .per_in_ready_o(per_in_ready_o), .per_out_valid_o(per_out_valid_o),
    .per_out_data_o(per_out_data_o), .per_out_ready_i(per_out_ready_i), .per_end_i(per_end_i)
  );

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic exp_run(input logic [AW-1:0] base, input int n, input logic w);
    for (int i = 0; i < n; i++) q.push_back('{a: base + AW'(i), w: w});
  endtask

  task automatic wr(input logic [3:0] a, input logic [AW-1:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [AW-1:0] d);
    @(posedge clk); #1;
    reg_addr_i = a;
    #2 d = reg_rdata_o;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 500; i++) begin
      if (irq_o) break;
      @(posedge clk); #1;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && mem_req_o && mem_gnt_i && !mem_err_i) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: got=unexpected beat at 0x%0h exp=no beat", mem_addr_o);
      end else begin
        exp_t it;
        it = q.pop_front();
        chk("R11 beat address", mem_addr_o, it.a);
        chk("R3 beat direction", {31'b0, mem_we_o}, {31'b0, it.w});
        if (it.w) chk("R3 write data", {24'b0, mem_wdata_o}, {24'b0, it.a[7:0] + 8'h11});
        else chk("R3 read data to peripheral", {23'b0, per_out_valid_o, per_out_data_o},
                 {23'b0, 1'b1, it.a[7:0] ^ 8'h5A});
      end
      if (mem_addr_o == watch_addr) gap_meas = cyc - last_cyc;
      last_cyc = cyc;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // reset state
    rd(A_CSR, v); chk("R2 reset status", v, 32'h0);
    chk("R8 irq at reset", {31'b0, irq_o}, 32'h0);
    chk("R5 no request at reset", {31'b0, mem_req_o}, 32'h0);

    // R1 readback
    wr(A_NEXT, 32'h100); wr(A_LIMIT, 32'h1FF); wr(A_START, 32'h180); wr(A_STOP, 32'h1C0);
    rd(A_NEXT, v);   chk("R1 next", v, 32'h100);
    rd(A_LIMIT, v);  chk("R1 limit", v, 32'h1FF);
    rd(A_START, v);  chk("R1 start", v, 32'h180);
    rd(A_STOP, v);   chk("R1 stop", v, 32'h1C0);
    rd(A_SNEXT, v);  chk("R1 saved next", v, 32'h100);
    rd(A_SLIMIT, v); chk("R1 saved limit", v, 32'h1FF);
    rd(A_SSTART, v); chk("R1 saved start", v, 32'h180);
    rd(A_SSTOP, v);  chk("R1 saved stop", v, 32'h1C0);

    // R2 arm with no grant, then reset+clear
    gnt_all = 1'b0;
    wr(A_CSR, 32'h07);
    rd(A_CSR, v); chk("R2 armed status", v, 32'h07);
    wr(A_CSR, 32'h30);
    rd(A_CSR, v); chk("R2 reset+clear status", v, 32'h04);
    chk("R5 no request after reset", {31'b0, mem_req_o}, 32'h0);

    // R3/R5/R11 write direction, single buffer, stalling grant
    gnt_half = 1'b1;
    wr(A_NEXT, 32'h20); wr(A_LIMIT, 32'h24);
    per_in_valid_i = 1'b1;
    exp_run(32'h20, 4, 1'b1);
    wr(A_CSR, 32'h39);
    wait_irq();
    repeat (4) @(posedge clk); #1;
    chk("R11 all beats seen", q.size(), 0);
    rd(A_CSR, v);  chk("R5 halted status", v, 32'h08);
    rd(A_NEXT, v); chk("R11 final next", v, 32'h24);
    chk("R5 no request after halt", {31'b0, mem_req_o}, 32'h0);
    gnt_half = 1'b0; gnt_all = 1'b1;
    wr(A_CSR, 32'h0);
    rd(A_CSR, v); chk("R1 zero write no effect", v, 32'h08);
    chk("R8 irq held", {31'b0, irq_o}, 32'h1);

    // R4/R8 chained read, re-arm in handler
    per_in_valid_i = 1'b0;
    wr(A_NEXT, 32'h40); wr(A_LIMIT, 32'h43); wr(A_START, 32'h80); wr(A_STOP, 32'h88);
    exp_run(32'h40, 3, 1'b0); exp_run(32'h80, 8, 1'b0); exp_run(32'hC0, 1, 1'b0);
    watch_addr = 32'h80;
    wr(A_CSR, 32'h37);
    wait_irq();
    rd(A_CSR, v); chk("R4 status after switch", v, 32'h0D);
    wr(A_START, 32'hC0); wr(A_STOP, 32'hC1); wr(A_CSR, 32'h16);
    chk("R8 irq cleared by clear-complete", {31'b0, irq_o}, 32'h0);
    wait_irq();
    repeat (6) @(posedge clk); #1;
    rd(A_CSR, v);    chk("R8 re-armed chain then halt", v, 32'h0C);
    chk("R4 switch spacing", gap_meas, 2);
    rd(A_SNEXT, v);  chk("R4 saved next after switch", v, 32'hC0);
    rd(A_SLIMIT, v); chk("R4 saved limit after switch", v, 32'hC1);
    rd(A_NEXT, v);   chk("R4 next at final limit", v, 32'hC1);
    chk("R4 all chained beats seen", q.size(), 0);
    watch_addr = '1;

    // R6 early end, R10 init
    wr(A_NEXT, 32'h200); wr(A_LIMIT, 32'h240);
    exp_run(32'h200, 5, 1'b1);
    wr(A_CSR, 32'h39);
    per_in_valid_i = 1'b1;
    repeat (5) begin @(posedge clk); #1; end
    per_in_valid_i = 1'b0; per_end_i = 1'b1;
    @(posedge clk); #1;
    per_end_i = 1'b0;
    rd(A_CSR, v);     chk("R6 status after early end", v, 32'h08);
    rd(A_SLIMIT, v);  chk("R6 saved limit reached", v, 32'h205);
    rd(A_SNEXT, v2);  chk("R6 saved next", v2, 32'h200);
    chk("R6 beat count", v - v2, 32'd5);
    rd(A_NEXT, v);    chk("R6 next held", v, 32'h205);
    wr(A_CSR, 32'h40);
    rd(A_SNEXT, v);   chk("R10 init saved next", v, 32'h205);
    rd(A_SLIMIT, v);  chk("R10 init saved limit", v, 32'h240);

    // R7 bus error
    err_en = 1'b1;
    wr(A_NEXT, 32'h300); wr(A_LIMIT, 32'h310);
    exp_run(32'h300, 3, 1'b1);
    per_in_valid_i = 1'b1;
    wr(A_CSR, 32'h39);
    wait_irq();
    rd(A_CSR, v);    chk("R7 status after bus error", v, 32'h18);
    rd(A_SLIMIT, v); chk("R7 saved limit at failing beat", v, 32'h303);
    rd(A_NEXT, v);   chk("R7 next at failing beat", v, 32'h303);
    chk("R7 no request after error", {31'b0, mem_req_o}, 32'h0);
    err_en = 1'b0; per_in_valid_i = 1'b0;
    wr(A_CSR, 32'h30);
    rd(A_CSR, v); chk("R2 reset clears bus exception", v, 32'h00);

    // R9 clear-complete colliding with limit event
    wr(A_NEXT, 32'h400); wr(A_LIMIT, 32'h402);
    exp_run(32'h400, 2, 1'b1);
    wr(A_CSR, 32'h39);
    per_in_valid_i = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    per_in_valid_i = 1'b0;
    reg_we_i = 1'b1; reg_addr_i = A_CSR; reg_wdata_i = 32'h10;
    @(posedge clk); #1;
    reg_we_i = 1'b0;
    chk("R9 irq survives colliding clear", {31'b0, irq_o}, 32'h1);
    rd(A_CSR, v); chk("R9 status after collision", v, 32'h08);
    wr(A_CSR, 32'h10);
    chk("R8 plain clear drops irq", {31'b0, irq_o}, 32'h0);

    repeat (3) @(posedge clk); #1;
    chk("R11 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule